// File: doc/BRIEF.md
# Analog Test Column-Group Selector

A pixel matrix of 640 columns has 8 analog test outputs. The columns form 80 groups of 8, and this block chooses which group is switched onto those outputs. It drives an 80-bit one-hot select to the analog multiplexer and also gives the position of the set bit as a 7-bit binary index.

There are two modes. In normal mode the pointer stays on group 0, so the first eight columns are watched all the time. In scan mode the pointer steps to the next group each time the row sequencer reports that a full 640-line frame has been read. After group 79 it wraps to group 0.

The mode request is sampled only on the end-of-frame strobe. A group is therefore never shown for part of a frame. When the block enters scan mode, group 0 keeps its slot for one more frame, because that frame starts in scan mode. Only after that frame does the pointer start to move.

Top module: `colgrp_sel`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the first cycle after it is released, `grp_sel` equals 1 (bit 0 set, group 0), `grp_idx` equals 0, and the block is in normal mode.
- R2: At every cycle after reset exactly one bit of `grp_sel` is set.
- R3: In any cycle where `frame_end` is low, neither `grp_sel` nor `grp_idx` changes on the next edge, whatever `scan_req` does.
- R4: On an edge where `frame_end` is high and `scan_req` is low, the block enters or stays in normal mode, and `grp_sel` becomes 1 (group 0).
- R5: On an edge where `frame_end` is high, `scan_req` is high and the block is in normal mode, the block enters scan mode and the selected group does not change.
- R6: On an edge where `frame_end` is high, `scan_req` is high and the block is already in scan mode, the set bit of `grp_sel` moves from position k to position k+1. A strobe that stays high for n cycles gives n steps.
- R7: A scan step taken from group 79 (bit 79) goes to group 0 (bit 0).
- R8: `grp_idx` always equals the bit position of the set bit in `grp_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_end | input | 1 | One-cycle strobe from the row sequencer at the end of a frame |
| scan_req | input | 1 | Requested mode: 1 = scan, 0 = normal; sampled on `frame_end` |
| grp_sel | output | 80 | One-hot column-group select to the analog multiplexer |
| grp_idx | output | 7 | Binary index of the selected group |

## Verification
The hardest case to reach is the wrap from group 79 back to group 0. It needs more than 80 completed frames in scan mode. With real frame lengths that would take far too long. The bench therefore shortens each frame to a few clock cycles between strobes and drives the pointer through a whole revolution. Stimulus also changes `scan_req` in the middle of a frame and holds the strobe high for several cycles in a row. A behavioural reference model is compared with both outputs on every clock.

// File: rtl/colgrp_pkg.sv
package colgrp_pkg;

    parameter int GROUPS_DEF = 80;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SCAN   = 1'b1
    } scan_mode_e;

    typedef struct packed {
        logic home;     // force pointer to group 0
        logic advance;  // move pointer one group on
    } ptr_step_t;

    // Decide what the pointer does on this edge.
    function automatic ptr_step_t step_of(input scan_mode_e cur,
                                          input logic strobe,
                                          input logic req);
        ptr_step_t s;
        s.home    = strobe && !req;
        s.advance = strobe && req && (cur == MODE_SCAN);
        return s;
    endfunction

endpackage

// File: rtl/colgrp_mode_ctl.sv
module colgrp_mode_ctl
    import colgrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_end,
    input  logic       scan_req,
    output scan_mode_e mode,
    output ptr_step_t  step
);

    scan_mode_e mode_q;

    // Mode is sampled only at a frame boundary.
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_NORMAL;
        else if (frame_end)
            mode_q <= scan_req ? MODE_SCAN : MODE_NORMAL;
    end

    assign mode = mode_q;
    assign step = step_of(mode_q, frame_end, scan_req);

    // R5
    enter_scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && scan_req && mode_q == MODE_NORMAL) |-> !step.advance);

endmodule

// File: rtl/colgrp_ring.sv
module colgrp_ring
    import colgrp_pkg::*;
#(
    parameter int GROUPS = GROUPS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_step_t         step,
    output logic [GROUPS-1:0] sel
);

    logic [GROUPS-1:0] sel_q;
    logic [GROUPS-1:0] sel_d;

    // Each bit takes its neighbour on advance; bit 0 closes the ring.
    for (genvar g = 0; g < GROUPS; g++) begin : g_bit
        if (g == 0) begin : g_head
            always_comb begin
                if (step.home)         sel_d[g] = 1'b1;
                else if (step.advance) sel_d[g] = sel_q[GROUPS-1];
                else                   sel_d[g] = sel_q[g];
            end
        end else begin : g_body
            always_comb begin
                if (step.home)         sel_d[g] = 1'b0;
                else if (step.advance) sel_d[g] = sel_q[g-1];
                else                   sel_d[g] = sel_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= GROUPS'(1);
        else     sel_q <= sel_d;
    end

    assign sel = sel_q;

    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_q) == 1);

    // R7
    ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step.advance && !step.home && sel_q[GROUPS-1]) |=> sel_q[0]);

endmodule

// File: rtl/colgrp_index.sv
module colgrp_index
    import colgrp_pkg::*;
#(
    parameter int GROUPS = GROUPS_DEF,
    parameter int IDXW   = $clog2(GROUPS)
) (
    input  logic            clk,
    input  logic            rst,
    input  ptr_step_t       step,
    output logic [IDXW-1:0] idx
);

    localparam logic [IDXW-1:0] LAST = IDXW'(GROUPS - 1);

    logic [IDXW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || step.home)
            idx_q <= '0;
        else if (step.advance)
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end

    assign idx = idx_q;

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST);

endmodule

// File: rtl/colgrp_sel.sv
module colgrp_sel
    import colgrp_pkg::*;
#(
    parameter int GROUPS = GROUPS_DEF,
    parameter int IDXW   = $clog2(GROUPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic              scan_req,
    output logic [GROUPS-1:0] grp_sel,
    output logic [IDXW-1:0]   grp_idx
);

    scan_mode_e mode;
    ptr_step_t  step;

    colgrp_mode_ctl u_mode (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .scan_req  (scan_req),
        .mode      (mode),
        .step      (step)
    );

    colgrp_ring #(.GROUPS(GROUPS)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .sel  (grp_sel)
    );

    colgrp_index #(.GROUPS(GROUPS), .IDXW(IDXW)) u_index (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .idx  (grp_idx)
    );

    // R3
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(grp_sel) && $stable(grp_idx)));

    // R4
    normal_home_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !scan_req) |=> (grp_sel[0] && grp_idx == '0));

    // R8
    idx_matches_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(grp_idx) < GROUPS) && grp_sel[grp_idx]);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (grp_sel == GROUPS'(1) && grp_idx == '0 && mode == MODE_NORMAL));

endmodule

// File: tb/colgrp_sel_test.sv
module colgrp_sel_test;

    localparam int NG = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_end = 1'b0;
    logic          scan_req = 1'b0;
    logic [NG-1:0] grp_sel;
    logic [6:0]    grp_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int ref_idx  = 0;
    bit ref_scan = 1'b0;
    bit ref_live = 1'b0;

    colgrp_sel uut (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .scan_req  (scan_req),
        .grp_sel   (grp_sel),
        .grp_idx   (grp_idx)
    );

    always #5 clk = ~clk;

    // Behavioural model: mode flag and integer group number.
    always @(posedge clk) begin
        if (rst) begin
            ref_idx  = 0;
            ref_scan = 1'b0;
            ref_live = 1'b1;
        end else if (frame_end) begin
            if (!scan_req) begin
                ref_idx  = 0;
                ref_scan = 1'b0;
            end else if (ref_scan) begin
                ref_idx = (ref_idx + 1) % NG;
            end else begin
                ref_scan = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (ref_live && !done) begin
            logic [NG-1:0] exp_vec;
            exp_vec = NG'(1) << ref_idx;
            checks++;
            if (grp_sel !== exp_vec) begin
                errors++;
                $display("FAIL R2 grp_sel actual=%h expected=%h", grp_sel, exp_vec);
            end
            chk("R8 grp_idx", int'(grp_idx), ref_idx);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input int gap);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        wait_cyc(gap);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 sel after reset", int'(grp_sel == NG'(1)), 1);
        chk("R1 idx after reset", int'(grp_idx), 0);

        // R4: normal mode, frames pass, pointer stays home
        for (int f = 0; f < 4; f++) frame(2);
        chk("R4 normal frames", int'(grp_idx), 0);

        // R3: request scan mid-frame, nothing moves
        scan_req = 1'b1;
        wait_cyc(4);
        chk("R3 mid-frame request", int'(grp_idx), 0);

        // R5: first strobe in scan only changes mode
        frame(2);
        chk("R5 entry frame keeps group", int'(grp_idx), 0);

        // R6: five scan frames
        for (int f = 0; f < 5; f++) frame(1);
        chk("R6 stepped five", int'(grp_idx), 5);
        chk("R6 sel bit five", int'(grp_sel[5]), 1);

        // R3: drop request mid-frame, still on group 5
        scan_req = 1'b0;
        wait_cyc(3);
        chk("R3 drop mid-frame", int'(grp_idx), 5);
        frame(1);
        chk("R4 back to normal", int'(grp_idx), 0);

        // R6: strobe held high three cycles
        scan_req = 1'b1;
        frame(1);
        frame_end = 1'b1;
        wait_cyc(3);
        frame_end = 1'b0;
        wait_cyc(1);
        chk("R6 held strobe", int'(grp_idx), 3);

        // R7: run to group 79 and wrap
        while (int'(grp_idx) != NG - 1) frame(0);
        chk("R7 at last group", int'(grp_sel[NG-1]), 1);
        frame(1);
        chk("R7 wrap idx", int'(grp_idx), 0);
        chk("R7 wrap sel", int'(grp_sel[0]), 1);
        frame(1);
        chk("R6 after wrap", int'(grp_idx), 1);

        // R1: reset during scan
        frame(1);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset in scan", int'(grp_idx), 0);
        frame(1);
        chk("R5 normal after reset", int'(grp_idx), 0);

        wait_cyc(2);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

endmodule